// File: doc/BRIEF.md
# Ten-bit I2C target address recogniser

This block is the receive-side front end of an I2C target that answers only to a 10-bit address. A fast system clock samples SCL and SDA. The block finds start, repeated-start and stop conditions and frames the bus into bytes of eight data bits plus one acknowledge bit. It pulls SDA low in the acknowledge slot when a byte concerns this target. Recognition takes two bytes. The header byte carries the fixed prefix `11110`, the two top address bits and the direction bit, and any target whose top bits agree may acknowledge it. The following byte must equal the low eight address bits exactly, and that byte singles out one target.

After a full write-direction address, the target is a receiver. Each data byte it takes is acknowledged and handed to the user logic. If the controller then issues a repeated start and resends the header with the read bit set, the already-addressed target acknowledges it and becomes a transmitter. The block then shifts user bytes out MSB first until the controller answers a byte with a non-acknowledge. A read header that is not preceded, since the last stop, by a completed two-byte write-direction address is not acknowledged.

Received bytes leave on `rx_valid`/`rx_data`. The bus cannot be stalled, so this stream has no back-pressure: the consumer must take every one-cycle `rx_valid` pulse. Transmit bytes enter on `tx_data`, which is treated as always valid while the block is a transmitter. A one-cycle `tx_ready` pulse marks the clock edge at which the present `tx_data` was taken, and the user should present the next byte after it.

Top module: `i2c10_target`

## Requirements
- R1: A falling SDA while SCL is high starts header reception and releases SDA. A rising SDA while SCL is high clears all addressing (`addressed`=0, `is_tx`=0) and releases SDA (`sda_oe`=0). The bus lines idle high and reset leaves every output at 0.
- R2: A header byte equal to `11110`, `own_addr[9:8]`, `0` (MSB first) is acknowledged: `sda_oe`=1 pulls SDA low during the ninth SCL pulse. A header whose prefix or high address bits differ is not acknowledged, and the bytes after it are not acknowledged either.
- R3: After an acknowledged write header, a second byte equal to `own_addr[7:0]` is acknowledged and sets `addressed`=1 and `is_tx`=0. Any other value gets no acknowledge, leaves the target unaddressed, and the data bytes after it are neither acknowledged nor delivered.
- R4: When addressed as a receiver, every data byte is acknowledged and presented MSB first on `rx_data` with a one-cycle `rx_valid` pulse at the falling SCL edge of its eighth bit.
- R5: After a repeated start, a target that holds a completed write-direction address acknowledges a header of `11110`, `own_addr[9:8]`, `1` and sets `is_tx`=1.
- R6: A header with the read bit set, received when no completed write-direction address exists since the last stop, is not acknowledged and leaves `is_tx`=0.
- R7: As a transmitter, the block takes `tx_data` with a `tx_ready` pulse at the falling SCL edge that ends each acknowledged ninth pulse. It drives that byte MSB first, each bit changing only after an SCL falling edge.
- R8: A non-acknowledge from the controller after a transmitted byte ends the transfer. SDA stays released (bytes read afterwards are 0xFF), and `is_tx` and `addressed` return to 0 until the next start.
- R9: A repeated start followed by an address that does not match (either header or low byte) removes the addressed state, and a later read header is then not acknowledged.
- R10: `sda_oe` changes only while SCL is low, so the target never creates a start or stop condition itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| own_addr | input | 10 | This target's 10-bit address |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a received byte |
| rx_data | output | 8 | Received data byte |
| tx_ready | output | 1 | One-cycle strobe: `tx_data` was taken for sending |
| tx_data | input | 8 | Next byte to transmit |
| addressed | output | 1 | Target currently selected |
| is_tx | output | 1 | Selected as transmitter (1) or receiver (0) |

## Verification
The bench acts as a bus controller and sends a matching write address followed by data. Against that, it sends a header with wrong high bits and a correct header followed by a wrong low byte, which shows the two match stages are independent. A read header is tried in three contexts: after a full write address, after a stop, and after a repeated start that changed the address. Only the first of these may be acknowledged. Transmitted bytes are read back with an acknowledge and then a non-acknowledge, to show that both continuation and release work.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_LOW, PH_RX, PH_TX, PH_SKIP
  } phase_e;
  localparam logic [4:0] HDR10_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c10_linesync.sv
module i2c10_linesync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
      logic [STAGES:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], din[i]};
      end
      assign dout[i] = chain[STAGES-1];
      assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
      assign fall[i] = ~chain[STAGES-1] & chain[STAGES];
    end
  endgenerate
endmodule

// File: rtl/i2c10_bitframe.sv
module i2c10_bitframe #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              scl_rise,
  input  logic              sda_bit,
  output logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] shreg
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (scl_rise && cnt != LAST) begin
      cnt   <= cnt + 1'b1;
      shreg <= {shreg[DATA_W-2:0], sda_bit};
    end
  end
endmodule

// File: rtl/i2c10_target.sv
module i2c10_target
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 10,
  localparam int CNT_W      = $clog2(DATA_W + 2),
  localparam int HI_W       = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              addressed,
  output logic              is_tx
);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(DATA_W + 1);

  logic [1:0] line_s, line_rise, line_fall;
  logic scl_sync, start_ev, stop_ev, byte_end, ack_end, restart;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg, txreg;
  logic hdr_ok, rw_bit, prev_addr;
  phase_e phase;

  i2c10_linesync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}),
    .dout(line_s), .rise(line_rise), .fall(line_fall)
  );

  assign scl_sync = line_s[0];
  assign start_ev = line_fall[1] & scl_sync;
  assign stop_ev  = line_rise[1] & scl_sync;
  assign byte_end = line_fall[0] && cnt == BYTE_END;
  assign ack_end  = line_fall[0] && cnt == ACK_END;
  assign restart  = start_ev | ack_end;

  i2c10_bitframe #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .scl_rise(line_rise[0]), .sda_bit(line_s[1]),
    .cnt(cnt), .shreg(shreg)
  );

  assign hdr_ok = shreg[DATA_W-1:1] == {HDR10_PREFIX, own_addr[ADDR_W-1 -: HI_W]};
  assign rw_bit = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      prev_addr <= 1'b0;
      sda_oe    <= 1'b0;
      txreg     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      tx_ready  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_ready <= 1'b0;
      if (stop_ev) begin
        phase     <= PH_IDLE;
        prev_addr <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (start_ev) begin
        phase  <= PH_HDR;
        sda_oe <= 1'b0;
      end else if (byte_end) begin
        unique case (phase)
          PH_HDR: begin
            if (hdr_ok && !rw_bit) begin
              sda_oe <= 1'b1;
              phase  <= PH_LOW;
            end else if (hdr_ok && rw_bit && prev_addr) begin
              sda_oe <= 1'b1;
              phase  <= PH_TX;
            end else begin
              phase     <= PH_SKIP;
              prev_addr <= 1'b0;
            end
          end
          PH_LOW: begin
            if (shreg == own_addr[DATA_W-1:0]) begin
              sda_oe    <= 1'b1;
              prev_addr <= 1'b1;
              phase     <= PH_RX;
            end else begin
              phase     <= PH_SKIP;
              prev_addr <= 1'b0;
            end
          end
          PH_RX: begin
            sda_oe   <= 1'b1;
            rx_valid <= 1'b1;
            rx_data  <= shreg;
          end
          PH_TX:   sda_oe <= 1'b0;
          default: sda_oe <= 1'b0;
        endcase
      end else if (ack_end) begin
        // the bit sampled in the ninth pulse is the acknowledge (0 = ack)
        if (phase == PH_TX && !shreg[0]) begin
          txreg    <= tx_data;
          sda_oe   <= ~tx_data[DATA_W-1];
          tx_ready <= 1'b1;
        end else begin
          sda_oe <= 1'b0;
          if (phase == PH_TX) phase <= PH_SKIP;
        end
      end else if (line_fall[0] && phase == PH_TX && cnt != '0 && cnt < BYTE_END) begin
        txreg  <= {txreg[DATA_W-2:0], 1'b0};
        sda_oe <= ~txreg[DATA_W-2];
      end
    end
  end

  assign addressed = prev_addr && phase != PH_SKIP && phase != PH_IDLE;
  assign is_tx     = phase == PH_TX;
endmodule

// File: rtl/i2c10_target_chk.sv
module i2c10_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_sync,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic rx_valid,
  input logic tx_ready,
  input logic addressed,
  input logic is_tx
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_sync);
  // R4
  rx_when_receiver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (addressed && !is_tx));
  // R7
  tx_when_transmitter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> is_tx);
  // R1
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!addressed && !is_tx && !sda_oe));
  // R1
  start_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);
  // R8
  tx_end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(is_tx) |-> !sda_oe);
endmodule

bind i2c10_target i2c10_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe), .rx_valid(rx_valid),
  .tx_ready(tx_ready), .addressed(addressed), .is_tx(is_tx)
);

// File: tb/i2c10_target_tb.sv
`timescale 1ns/1ps
module i2c10_target_tb;
  localparam int H = 20;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic sda_oe, rx_valid, tx_ready, addressed, is_tx;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic [9:0] own = 10'h2A5;
  wire sda_bus = msda & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, tx_allowed = 1'b0, prev_oe = 1'b0;
  logic [7:0] exp_rx[$];
  logic [7:0] tx_q[$];

  i2c10_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .own_addr(own), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_data(tx_data), .addressed(addressed), .is_tx(is_tx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output bit s);
    scl = 1'b1; wt(H/2); s = sda_bus; wt(H/2);
    scl = 1'b0; wt(4);
  endtask

  task automatic m_start();
    msda = 1'b1; scl = 1'b1; wt(H); msda = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic m_rstart();
    msda = 1'b1; wt(H); scl = 1'b1; wt(H); msda = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic m_stop();
    msda = 1'b0; wt(H); scl = 1'b1; wt(H); msda = 1'b1; wt(H);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wt(H); pulse(s);
    end
    msda = 1'b1; wt(H); pulse(s);
    ack = !s;
  endtask

  task automatic m_rbyte(input bit give_ack, output logic [7:0] b);
    bit s;
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); pulse(s); b[i] = s;
    end
    msda = !give_ack; wt(H); pulse(s); msda = 1'b1;
  endtask

  // per-clock reference comparison of the strobes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid) begin
        if (exp_rx.size() == 0) chk(1'b0, "R4 unexpected rx_valid", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R4 rx byte", rx_data, e);
        end
      end
      if (tx_ready) begin
        chk(tx_allowed, "R7 tx_ready only as transmitter", 1, 0);
        if (tx_q.size() > 0) tx_data = tx_q.pop_front();
      end
      if (sda_oe != prev_oe) chk(scl == 1'b0, "R10 sda_oe change with SCL low", scl, 0);
      prev_oe = sda_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    wt(5); rst_n = 1'b1; wt(3);
    chk(!sda_oe && !addressed && !is_tx && !rx_valid && !tx_ready, "R1 reset state",
        {sda_oe, addressed, is_tx}, 0);

    // full write address then two data bytes (header F4 = 11110_10_0, low A5)
    m_start();
    m_wbyte(8'hF4, ack); chk(ack, "R2 write header ack", ack, 1);
    m_wbyte(8'hA5, ack); chk(ack, "R3 low byte ack", ack, 1);
    chk(addressed && !is_tx, "R3 addressed as receiver", {addressed, is_tx}, 2);
    exp_rx.push_back(8'h3C); m_wbyte(8'h3C, ack); chk(ack, "R4 data ack", ack, 1);
    exp_rx.push_back(8'hC3); m_wbyte(8'hC3, ack); chk(ack, "R4 data ack", ack, 1);
    m_stop(); wt(6);
    chk(!addressed && !sda_oe, "R1 stop clears", {addressed, sda_oe}, 0);
    chk(exp_rx.size() == 0, "R4 all bytes delivered", exp_rx.size(), 0);

    // wrong high address bits
    m_start();
    m_wbyte(8'hF6, ack); chk(!ack, "R2 wrong header nack", ack, 0);
    m_wbyte(8'hA5, ack); chk(!ack, "R2 following byte nack", ack, 0);
    m_stop(); wt(6);

    // right header, wrong low byte
    m_start();
    m_wbyte(8'hF4, ack); chk(ack, "R2 header ack", ack, 1);
    m_wbyte(8'hA4, ack); chk(!ack, "R3 wrong low byte nack", ack, 0);
    chk(!addressed, "R3 not addressed", addressed, 0);
    m_wbyte(8'h11, ack); chk(!ack, "R3 data ignored", ack, 0);
    m_stop(); wt(6);

    // read header with no prior address
    m_start();
    m_wbyte(8'hF5, ack); chk(!ack, "R6 read header without address", ack, 0);
    chk(!is_tx, "R6 stays non-transmitter", is_tx, 0);
    m_stop(); wt(6);

    // write address, repeated start, read two bytes
    m_start();
    m_wbyte(8'hF4, ack); m_wbyte(8'hA5, ack);
    tx_data = 8'h96; tx_q.push_back(8'h5A); tx_q.push_back(8'h00);
    tx_allowed = 1'b1;
    m_rstart();
    m_wbyte(8'hF5, ack); chk(ack, "R5 read header ack", ack, 1);
    chk(is_tx && addressed, "R5 transmitter mode", {is_tx, addressed}, 3);
    m_rbyte(1'b1, rb); chk(rb == 8'h96, "R7 first byte", rb, 8'h96);
    m_rbyte(1'b0, rb); chk(rb == 8'h5A, "R7 second byte", rb, 8'h5A);
    wt(6);
    tx_allowed = 1'b0;
    chk(!is_tx && !addressed && !sda_oe, "R8 nack ends transfer",
        {is_tx, addressed, sda_oe}, 0);
    m_rbyte(1'b0, rb); chk(rb == 8'hFF, "R8 SDA released", rb, 8'hFF);
    m_stop(); wt(6);

    // stop forgets the address
    m_start();
    m_wbyte(8'hF4, ack); m_wbyte(8'hA5, ack);
    m_stop(); wt(6);
    m_start();
    m_wbyte(8'hF5, ack); chk(!ack, "R6 read after stop nack", ack, 0);
    m_stop(); wt(6);

    // repeated start to another address drops selection
    m_start();
    m_wbyte(8'hF4, ack); m_wbyte(8'hA5, ack);
    m_rstart();
    m_wbyte(8'hF4, ack); chk(ack, "R9 shared header ack", ack, 1);
    m_wbyte(8'h5A, ack); chk(!ack, "R9 other low byte nack", ack, 0);
    chk(!addressed, "R9 deselected", addressed, 0);
    m_rstart();
    m_wbyte(8'hF5, ack); chk(!ack, "R9 read after deselect nack", ack, 0);
    m_stop(); wt(6);
    chk(exp_rx.size() == 0, "R4 no stray bytes", exp_rx.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule